// File: doc/BRIEF.md
# Modem Status Change Detector

This block is the read-only modem status register of a serial port. It watches four active-low handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. It reports their present levels in inverted form in the upper half of an eight-bit read word. In the lower half it keeps sticky change flags. Software reads the word through a one-cycle read strobe, and that read clears the flags. The lines give status only and have no influence on any transfer path.

Each external line passes through a synchronizer. A change is then found by comparing the selected level against a registered copy of it. A loopback switch replaces the four pins with bits of a modem control value, in a fixed reordered mapping. Any change caused by that switch is flagged like a pin change. An interrupt request is raised while a flag is set and the interrupt enable is high.

Top module: `mdm_status_reg`

## Requirements
- R1: After reset, rd_data_o is 8'h00 and irq_o is 0 while all four pins are held high.
- R2: Bits 7, 6, 5 and 4 of rd_data_o hold the inverted levels of dcd_n_i, ri_n_i, dsr_n_i and cts_n_i, which is the order of the bits from 7 down to 4. A pin change shows in the status bit after exactly three rising clock edges: two synchronizer stages and one status register.
- R3: Bit 0 sets on any change of the clear-to-send status. Bit 1 sets on any change of data-set-ready. Bit 3 sets on any change of carrier detect.
- R4: Bit 2 sets only when ri_n_i goes from low to high, which means status bit 6 falls from 1 to 0. A high-to-low change of ri_n_i leaves bit 2 unchanged.
- R5: A set flag in bits 3:0 stays set, whatever the inputs do, until a read.
- R6: During a cycle with rd_stb_i high, rd_data_o shows the flags as they were before the clear. At the following edge, bits 3:0 clear. Bits 7:4 are not altered by the read.
- R7: A change that is detected at the same edge as a read leaves its flag set after the read.
- R8: With loop_en_i high, the status bits follow ctrl_i one edge later. Bit 4 takes ctrl_i[1], bit 5 takes ctrl_i[0], bit 6 takes ctrl_i[2] and bit 7 takes ctrl_i[3]. The pins have no effect in this mode.
- R9: Turning loop_en_i on or off flags every status line whose effective level changes because of the switch. The ring flag follows the rule in R4.
- R10: irq_o is high exactly when irq_en_i is high and any of rd_data_o[3:0] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| ctrl_i | input | 4 | Modem control bits used as the source in loopback |
| loop_en_i | input | 1 | Loopback select |
| rd_stb_i | input | 1 | Register read strobe; clears the change flags |
| irq_en_i | input | 1 | Modem status interrupt enable |
| rd_data_o | output | 8 | Status word: levels in 7:4, change flags in 3:0 |
| irq_o | output | 1 | Status change interrupt request |

## Verification
The stimulus drops each pin low one at a time, then releases them together. This separates the three any-change flags from the ring flag and shows that a ring pin falling sets nothing while a ring pin rising does. Loopback runs walk a single control bit across positions. This exposes any error in the reordered mapping, and a pin pattern driven during loopback shows that the pins are ignored. Leaving loopback with the pins low, and changing a line in the same cycle as a read, cover the switch-over flagging and the rule that a new set wins over a clear. Exact-cycle samples after a pin edge pin down the synchronizer depth.

// File: rtl/mdm_status_pkg.sv
package mdm_status_pkg;

   localparam int unsigned LINES = 4;

   localparam int unsigned LN_CTS = 0;
   localparam int unsigned LN_DSR = 1;
   localparam int unsigned LN_RI  = 2;
   localparam int unsigned LN_DCD = 3;

   typedef enum logic {
      EDGE_ANY   = 1'b0,
      EDGE_TRAIL = 1'b1
   } edge_mode_e;

   // control bit feeding each status line while looped back
   function automatic int unsigned loop_src(input int unsigned ln);
      case (ln)
         LN_CTS:  return 1;
         LN_DSR:  return 0;
         LN_RI:   return 2;
         default: return 3;
      endcase
   endfunction

   function automatic edge_mode_e line_mode(input int unsigned ln);
      return (ln == LN_RI) ? EDGE_TRAIL : EDGE_ANY;
   endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mdm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{{WIDTH{RESET_VAL}}}};
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdm_src_mux.sv
module mdm_src_mux
   import mdm_status_pkg::*;
(
   input  logic [LINES-1:0] pin_n_i,
   input  logic [LINES-1:0] ctrl_i,
   input  logic             loop_i,
   output logic [LINES-1:0] lvl_o
);

   for (genvar ln = 0; ln < LINES; ln++) begin : g_line
      localparam int unsigned SRC = loop_src(ln);
      assign lvl_o[ln] = loop_i ? ctrl_i[SRC] : ~pin_n_i[ln];
   end

endmodule

// File: rtl/mdm_delta_cell.sv
module mdm_delta_cell
   import mdm_status_pkg::*;
#(
   parameter edge_mode_e MODE = EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_i,
   output logic lvl_q_o,
   output logic flag_o
);

   logic lvl_q;
   logic flag_q;
   logic hit;

   generate
      if (MODE == EDGE_ANY) begin : g_any
         assign hit = lvl_i ^ lvl_q;
      end else begin : g_trail
         // status falling means the active-low pin went high
         assign hit = lvl_q & ~lvl_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         lvl_q  <= lvl_i;
         flag_q <= hit | (flag_q & ~clr_i);
      end
   end

   assign lvl_q_o = lvl_q;
   assign flag_o  = flag_q;

endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
   import mdm_status_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cts_n_i,
   input  logic             dsr_n_i,
   input  logic             ri_n_i,
   input  logic             dcd_n_i,
   input  logic [3:0]       ctrl_i,
   input  logic             loop_en_i,
   input  logic             rd_stb_i,
   input  logic             irq_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic             irq_o
);

   localparam int unsigned FLAG_LO = 0;
   localparam int unsigned LVL_LO  = FLAG_LO + LINES;

   generate
      if (DATA_W != 2 * LINES) begin : g_bad_width
         $error("mdm_status_reg: DATA_W must be twice LINES");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mdm_status_reg: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [LINES-1:0] pin_raw_n;
   logic [LINES-1:0] pin_sync_n;
   logic [LINES-1:0] lvl_sel;
   logic [LINES-1:0] lvl_q;
   logic [LINES-1:0] flag_q;

   assign pin_raw_n[LN_CTS] = cts_n_i;
   assign pin_raw_n[LN_DSR] = dsr_n_i;
   assign pin_raw_n[LN_RI]  = ri_n_i;
   assign pin_raw_n[LN_DCD] = dcd_n_i;

   mdm_sync #(
      .WIDTH     (LINES),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_raw_n),
      .sync_o  (pin_sync_n)
   );

   mdm_src_mux mux_i (
      .pin_n_i (pin_sync_n),
      .ctrl_i  (ctrl_i),
      .loop_i  (loop_en_i),
      .lvl_o   (lvl_sel)
   );

   for (genvar ln = 0; ln < LINES; ln++) begin : g_cell
      mdm_delta_cell #(
         .MODE (line_mode(ln))
      ) cell_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (lvl_sel[ln]),
         .clr_i   (rd_stb_i),
         .lvl_q_o (lvl_q[ln]),
         .flag_o  (flag_q[ln])
      );
   end

   assign rd_data_o[LVL_LO +: LINES]  = lvl_q;
   assign rd_data_o[FLAG_LO +: LINES] = flag_q;
   assign irq_o = irq_en_i & (|flag_q);

endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] ctrl_i,
   input logic       loop_en_i,
   input logic       rd_stb_i,
   input logic       irq_en_i,
   input logic [7:0] rd_data_o,
   input logic       irq_o
);

   assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> ((rd_data_o[3:0] & $past(rd_data_o[3:0])) == $past(rd_data_o[3:0])));

   assert_cts_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data_o[0]) |-> (rd_data_o[4] != $past(rd_data_o[4])));

   assert_ri_trail_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data_o[2]) |-> $fell(rd_data_o[6]));

   assert_ri_lead_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_data_o[6]) && !$past(rd_data_o[2])) |-> !rd_data_o[2]);

   assert_loop_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en_i |=> (rd_data_o[7:4] ==
         {$past(ctrl_i[3]), $past(ctrl_i[2]), $past(ctrl_i[0]), $past(ctrl_i[1])}));

   assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_stb_i) && (rd_data_o[5] != $past(rd_data_o[5]))) |-> rd_data_o[1]);

   assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en_i && (rd_data_o[3:0] != 4'h0)));

endmodule

bind mdm_status_reg mdm_status_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_i    (ctrl_i),
   .loop_en_i (loop_en_i),
   .rd_stb_i  (rd_stb_i),
   .irq_en_i  (irq_en_i),
   .rd_data_o (rd_data_o),
   .irq_o     (irq_o)
);

// File: tb/mdm_status_reg_tb.sv
module mdm_status_reg_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pins = 4'hF;   // [0]cts [1]dsr [2]ri [3]dcd, active low
   logic [3:0] ctrl = 4'h0;
   logic       loop = 1'b0;
   logic       rd_stb = 1'b0;
   logic       irq_en = 1'b1;
   logic [7:0] rd_data;
   logic       irq;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   mdm_status_reg dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cts_n_i   (pins[0]),
      .dsr_n_i   (pins[1]),
      .ri_n_i    (pins[2]),
      .dcd_n_i   (pins[3]),
      .ctrl_i    (ctrl),
      .loop_en_i (loop),
      .rd_stb_i  (rd_stb),
      .irq_en_i  (irq_en),
      .rd_data_o (rd_data),
      .irq_o     (irq)
   );

   typedef struct packed {
      logic       lp;
      logic [3:0] ct;
      logic [3:0] pn;
      logic       rd;
      logic [7:0] ex;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 4'h0, 4'b1110, 1'b1, 8'h11},  // R2 R3 cts low
      '{1'b0, 4'h0, 4'b1100, 1'b1, 8'h32},  // R3 dsr low
      '{1'b0, 4'h0, 4'b1000, 1'b1, 8'h70},  // R4 ri falls: no flag
      '{1'b0, 4'h0, 4'b1100, 1'b1, 8'h34},  // R4 ri rises: flag
      '{1'b0, 4'h0, 4'b0100, 1'b1, 8'hB8},  // R3 dcd low
      '{1'b0, 4'h0, 4'b1111, 1'b1, 8'h0B},  // R3 release together
      '{1'b0, 4'h0, 4'b1110, 1'b0, 8'h11},  // R5 no read
      '{1'b0, 4'h0, 4'b1111, 1'b1, 8'h01},  // R5 flag kept
      '{1'b1, 4'h2, 4'b1111, 1'b1, 8'h11},  // R8 ctrl1 -> bit4
      '{1'b1, 4'h1, 4'b1111, 1'b1, 8'h23},  // R8 ctrl0 -> bit5
      '{1'b1, 4'h4, 4'b1111, 1'b1, 8'h42},  // R8 ctrl2 -> bit6
      '{1'b1, 4'h0, 4'b1111, 1'b1, 8'h04},  // R4 R8 ri trail in loop
      '{1'b1, 4'h8, 4'b0000, 1'b1, 8'h88},  // R8 pins ignored
      '{1'b0, 4'h8, 4'b0000, 1'b1, 8'hF3},  // R9 leave loopback
      '{1'b0, 4'h0, 4'b1111, 1'b1, 8'h0F}   // R3 R4 all release
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read(input logic [7:0] exp);
      rd_stb = 1'b1;
      #1 check("R6 pre-clear read", rd_data, exp);
      @(negedge clk);
      rd_stb = 1'b0;
      #1 check("R6 cleared after read", rd_data, {exp[7:4], 4'h0});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(4);
      check("R1 reset data", rd_data, 8'h00);
      check("R1 reset irq", {7'b0, irq}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         loop = VECS[i].lp;
         ctrl = VECS[i].ct;
         pins = VECS[i].pn;
         tick(4);
         #1 check($sformatf("R2/R3/R4/R8/R9 vector %0d", i), rd_data, VECS[i].ex);
         check($sformatf("R10 irq vector %0d", i), {7'b0, irq},
               {7'b0, (VECS[i].ex[3:0] != 4'h0)});
         @(negedge clk);
         if (VECS[i].rd) do_read(VECS[i].ex);
      end

      // R2 exact latency: change not visible after two edges, visible after three
      pins = 4'b1110;
      tick(2);
      #1 check("R2 hidden after 2 edges", rd_data, 8'h00);
      @(negedge clk);
      #1 check("R2 visible after 3 edges", rd_data, 8'h11);
      @(negedge clk);
      do_read(8'h11);

      // R10 enable gating
      irq_en = 1'b0;
      pins = 4'b1111;
      tick(4);
      #1 check("R10 irq masked", {7'b0, irq}, 8'h00);
      irq_en = 1'b1;
      #1 check("R10 irq unmasked", {7'b0, irq}, 8'h01);
      @(negedge clk);
      do_read(8'h01);

      // R7 change at the same edge as a read
      loop = 1'b1;
      ctrl = 4'h2;
      tick(2);
      #1 check("R7 setup", rd_data, 8'h11);
      @(negedge clk);
      rd_stb = 1'b1;
      ctrl = 4'h3;
      #1 check("R7 read shows old", rd_data, 8'h11);
      @(negedge clk);
      rd_stb = 1'b0;
      #1 check("R7 new flag kept", rd_data, 8'h32);
      @(negedge clk);
      do_read(8'h32);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule